// File: doc/BRIEF.md
# Seven-Bit Quasi-Bidirectional Port with Alternate Functions

This block is the output latch, pin drive and read path of one general-purpose port in a small 8-bit microcontroller. Software writes the latch through a simple register-write strobe. Each pin is driven as an open-drain pull-down. A weak pull-up indication is given whenever the pin is not being pulled low. A pin with a latch bit of one therefore behaves as an input that idles high, and any outside driver can pull it low.

The port has seven pins at bit positions 0 to 5 and 7. Position 6 has no pin. The synchronised pin levels go to the serial receiver, the two active-low external interrupts (these also act as the counter gate controls) and the two counter clock inputs. The serial transmitter's output is combined with the latch bit on the transmit pin.

There are two kinds of read:
- A read-modify-write access returns the latch contents.
- A plain read returns the pin levels after the synchroniser.

Top module: `qport_top`

## Requirements
- R1: A synchronous active-high reset sets every latch bit to one. A read-modify-write read then returns 8'hFF, and no pull-down is active on any pin other than the transmit pin (bit 1).
- R2: One clock edge with `wr_en` high loads `wr_data` into the latch. A read with `rd_rmw`=1 returns the latch contents on `rd_data`.
- R3: Position 6 is absent. `rd_data[6]` is always 1 for both read kinds, writes to bit 6 have no effect, and `pull_dn[6]` and `pull_up[6]` are always 0.
- R4: A read with `rd_rmw`=0 returns the pin levels through a two-flop synchroniser. A change on `pin_in` appears on `rd_data` after exactly two rising clock edges, and not after one.
- R5: On each implemented bit, the effective drive is the latch bit ANDed with that pin's alternate output. `pull_dn` is the inverse of the effective drive. Bit 1's alternate output is `ser_txd`. All other pins use a constant 1 as their alternate output.
- R6: A latch bit of 0 forces `pull_dn` of that pin to 1, whatever the alternate output is.
- R7: On each implemented bit, exactly one of `pull_up` and `pull_dn` is 1.
- R8: The outputs are the synchronised pin levels, each with the same two-edge latency as R4:
  - `ser_rxd` is bit 0.
  - `int0_n` is bit 2 and `int1_n` is bit 3.
  - `cnt0_in` is bit 4 and `cnt1_in` is bit 5.

  These outputs follow the pins whatever the latch holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Latch write value |
| rd_rmw | input | 1 | 1: read returns the latch; 0: read returns the pins |
| rd_data | output | 8 | Read value |
| pin_in | input | 8 | Pad input levels (bit 6 unused) |
| pull_dn | output | 8 | 1 = pull the pin low |
| pull_up | output | 8 | 1 = weak pull-up active |
| ser_txd | input | 1 | Serial transmitter output |
| ser_rxd | output | 1 | Synchronised receive data (bit 0) |
| int0_n | output | 1 | Synchronised interrupt 0 / counter 0 gate (bit 2) |
| int1_n | output | 1 | Synchronised interrupt 1 / counter 1 gate (bit 3) |
| cnt0_in | output | 1 | Synchronised counter 0 input (bit 4) |
| cnt1_in | output | 1 | Synchronised counter 1 input (bit 5) |

## Verification
The bench builds the block with its default parameters: an 8-position map with position 6 masked out, and two synchroniser stages. These values make the missing-bit behaviour visible at the ports on both read kinds and on the drive outputs. They also let the bench count the two-edge latency exactly, by checking for the old value after one edge and the new value after two. With the latch held at one and then cleared, the bench toggles the transmitter output and shows both the pass-through case and the forced-low case.

// File: rtl/qport_pkg.sv
package qport_pkg;

    localparam int PORT_W        = 8;
    localparam logic [7:0] IMPL_MASK = 8'hBF;

    localparam int POS_RXD  = 0;
    localparam int POS_TXD  = 1;
    localparam int POS_INT0 = 2;
    localparam int POS_INT1 = 3;
    localparam int POS_CNT0 = 4;
    localparam int POS_CNT1 = 5;

    typedef struct packed {
        logic rxd;
        logic int0_n;
        logic int1_n;
        logic cnt0;
        logic cnt1;
    } alt_in_t;

    function automatic logic [PORT_W-1:0] fill_absent(
        input logic [PORT_W-1:0] v,
        input logic [PORT_W-1:0] mask
    );
        return v | ~mask;
    endfunction

endpackage

// File: rtl/qport_latch.sv
module qport_latch #(
    parameter int W = 8,
    parameter logic [W-1:0] MASK = 8'hBF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] latch_q
);
    import qport_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
        end else if (wr_en) begin
            latch_q <= fill_absent(wr_data, MASK);
        end
    end
endmodule

// File: rtl/qport_sync.sv
module qport_sync #(
    parameter int W = 8,
    parameter logic [W-1:0] MASK = 8'hBF,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], d[i]};
                end
            end
            assign q[i] = chain[STAGES-1];
        end else begin : g_absent
            assign q[i] = 1'b1;
        end
    end
endmodule

// File: rtl/qport_drive.sv
module qport_drive #(
    parameter int W = 8,
    parameter logic [W-1:0] MASK = 8'hBF
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] alt_out,
    output logic [W-1:0] pull_dn,
    output logic [W-1:0] pull_up
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            logic eff;
            assign eff        = latch_q[i] & alt_out[i];
            assign pull_dn[i] = ~eff;
            assign pull_up[i] = eff;
        end else begin : g_absent
            assign pull_dn[i] = 1'b0;
            assign pull_up[i] = 1'b0;
        end
    end
endmodule

// File: rtl/qport_top.sv
module qport_top
    import qport_pkg::*;
#(
    parameter int W = PORT_W,
    parameter logic [W-1:0] MASK = IMPL_MASK,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_rmw,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pull_dn,
    output logic [W-1:0] pull_up,
    input  logic         ser_txd,
    output logic         ser_rxd,
    output logic         int0_n,
    output logic         int1_n,
    output logic         cnt0_in,
    output logic         cnt1_in
);
    logic [W-1:0] latch_q;
    logic [W-1:0] pin_sync;
    logic [W-1:0] alt_out;
    alt_in_t      alt_in;

    qport_latch #(.W(W), .MASK(MASK)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .latch_q (latch_q)
    );

    qport_sync #(.W(W), .MASK(MASK), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    always_comb begin
        alt_out          = '1;
        alt_out[POS_TXD] = ser_txd;
    end

    qport_drive #(.W(W), .MASK(MASK)) u_drive (
        .latch_q (latch_q),
        .alt_out (alt_out),
        .pull_dn (pull_dn),
        .pull_up (pull_up)
    );

    always_comb begin
        alt_in.rxd    = pin_sync[POS_RXD];
        alt_in.int0_n = pin_sync[POS_INT0];
        alt_in.int1_n = pin_sync[POS_INT1];
        alt_in.cnt0   = pin_sync[POS_CNT0];
        alt_in.cnt1   = pin_sync[POS_CNT1];
    end

    assign ser_rxd = alt_in.rxd;
    assign int0_n  = alt_in.int0_n;
    assign int1_n  = alt_in.int1_n;
    assign cnt0_in = alt_in.cnt0;
    assign cnt1_in = alt_in.cnt1;

    assign rd_data = fill_absent(rd_rmw ? latch_q : pin_sync, MASK);
endmodule

// File: rtl/qport_checks.sv
module qport_checks (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_rmw,
    input logic [7:0] rd_data,
    input logic [7:0] pin_in,
    input logic [7:0] pull_dn,
    input logic [7:0] pull_up,
    input logic       ser_txd,
    input logic       ser_rxd,
    input logic       int0_n,
    input logic       int1_n,
    input logic       cnt0_in,
    input logic       cnt1_in
);
    logic [1:0] run_cnt;
    logic       seen_clk;
    always_ff @(posedge clk) begin
        seen_clk <= 1'b1;
        if (rst) run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    a_r1_reset_ones: assert property (@(posedge clk)
        rst |=> (((pull_dn & 8'hFD) == 8'h00) && (!rd_rmw || rd_data == 8'hFF)));

    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!rd_rmw || rd_data == ($past(wr_data) | 8'h40)));

    a_r3_bit6_fixed: assert property (@(posedge clk) disable iff (rst)
        seen_clk |-> (rd_data[6] && !pull_dn[6] && !pull_up[6]));

    a_r4_sync_two: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == 2'd3 && !rd_rmw) |->
            ((rd_data & 8'hBF) == ($past(pin_in, 2) & 8'hBF)));

    a_r5_tx_drive: assert property (@(posedge clk) disable iff (rst)
        rd_rmw |-> (pull_dn[1] == !(rd_data[1] & ser_txd)));

    a_r6_zero_low: assert property (@(posedge clk) disable iff (rst)
        rd_rmw |-> ((~rd_data & ~pull_dn & 8'hBF) == 8'h00));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        seen_clk |-> (((pull_up ^ pull_dn) & 8'hBF) == 8'hBF));

    a_r8_alt_route: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == 2'd3) |->
            ({cnt1_in, cnt0_in, int1_n, int0_n, ser_rxd} ==
             {$past(pin_in[5], 2), $past(pin_in[4], 2), $past(pin_in[3], 2),
              $past(pin_in[2], 2), $past(pin_in[0], 2)}));
endmodule

bind qport_top qport_checks u_checks (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_rmw  (rd_rmw),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pull_dn (pull_dn),
    .pull_up (pull_up),
    .ser_txd (ser_txd),
    .ser_rxd (ser_rxd),
    .int0_n  (int0_n),
    .int1_n  (int1_n),
    .cnt0_in (cnt0_in),
    .cnt1_in (cnt1_in)
);

// File: tb/qport_top_test.sv
module qport_top_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rd_rmw;
    logic [7:0] rd_data;
    logic [7:0] pin_in;
    logic [7:0] pull_dn;
    logic [7:0] pull_up;
    logic       ser_txd;
    logic       ser_rxd, int0_n, int1_n, cnt0_in, cnt1_in;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    qport_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_rmw(rd_rmw), .rd_data(rd_data), .pin_in(pin_in),
        .pull_dn(pull_dn), .pull_up(pull_up), .ser_txd(ser_txd),
        .ser_rxd(ser_rxd), .int0_n(int0_n), .int1_n(int1_n),
        .cnt0_in(cnt0_in), .cnt1_in(cnt1_in)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; rd_rmw = 1'b1;
        pin_in = 8'hFF; ser_txd = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);
        check8("R1 rmw read after reset", rd_data, 8'hFF);
        check8("R1 no pull-down after reset", pull_dn, 8'h00);
    endtask

    task automatic t_write_rmw;
        rd_rmw = 1'b1;
        do_write(8'hA5);
        check8("R2 latch A5", rd_data, 8'hE5);
        do_write(8'h3A);
        check8("R2 latch 3A", rd_data, 8'h7A);
        do_write(8'hFF);
    endtask

    task automatic t_bit6;
        rd_rmw = 1'b1;
        do_write(8'h00);
        check8("R3 bit6 rmw after zero write", {7'd0, rd_data[6]}, 8'h01);
        check8("R3 bit6 drive", {6'd0, pull_dn[6], pull_up[6]}, 8'h00);
        rd_rmw = 1'b0; pin_in = 8'h00;
        step(3);
        check8("R3 bit6 pin read", rd_data, 8'h40);
        pin_in = 8'hFF;
        do_write(8'hFF);
        step(2);
    endtask

    task automatic t_sync;
        rd_rmw = 1'b0;
        pin_in = 8'hFF; step(3);
        pin_in = 8'h96;
        step(1);
        check8("R4 one edge keeps old", rd_data, 8'hFF);
        step(1);
        check8("R4 two edges show new", rd_data, 8'hD6);
        pin_in = 8'h29;
        step(2);
        check8("R4 second pattern", rd_data, 8'h69);
    endtask

    task automatic t_drive;
        rd_rmw = 1'b1;
        do_write(8'hFF);
        ser_txd = 1'b0; step(1);
        check8("R5 tx low pulls bit1", pull_dn, 8'h02);
        ser_txd = 1'b1; step(1);
        check8("R5 tx high releases", pull_dn, 8'h00);
        check8("R7 pull-up where released", pull_up, 8'hBF);
    endtask

    task automatic t_force_low;
        do_write(8'hC2 & 8'h00 | 8'h11);
        ser_txd = 1'b1; step(1);
        check8("R6 zero latch forces low", pull_dn, 8'hAE);
        check8("R7 pull-up complement", pull_up, 8'h11);
        do_write(8'h00);
        ser_txd = 1'b0; step(1);
        check8("R6 bit1 low with tx low", pull_dn, 8'hBF);
        ser_txd = 1'b1; step(1);
        check8("R6 bit1 low with tx high", pull_dn, 8'hBF);
    endtask

    task automatic t_alt;
        // latch currently zero: routing must not depend on it
        pin_in = 8'hFF; step(3);
        pin_in = 8'b1001_0100;
        step(1);
        check8("R8 alt one edge old", {3'd0, cnt1_in, cnt0_in, int1_n, int0_n, ser_rxd}, 8'h1F);
        step(1);
        check8("R8 alt two edges", {3'd0, cnt1_in, cnt0_in, int1_n, int0_n, ser_rxd}, 8'h0A);
        pin_in = 8'b0010_1001;
        step(2);
        check8("R8 alt second pattern", {3'd0, cnt1_in, cnt0_in, int1_n, int0_n, ser_rxd}, 8'h15);
        do_write(8'hFF);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_write_rmw();
        t_bit6();
        t_sync();
        t_drive();
        t_force_low();
        t_alt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule